// File: doc/BRIEF.md
# Program/Erase Engine with Busy Status

This block carries out word-program and range-erase requests from a command decoder against a word array it holds inside. Each operation runs for a fixed number of clock cycles set by a parameter, so no timing stimulus is needed beyond the system clock. A program request never sets a bit. The stored word becomes the old word ANDed with the new data. An erase writes all ones over a range of words, given as a start address and a length in words. The range wraps at the top of the array.

While an operation runs, host reads do not return array data. They return a status word. In that word, bit 7 carries the data-polling value and bit 6 flips on every read. The engine also drives write-strobe outputs for each array write it performs. A power-on lockout timer blocks requests for a set time after reset. An abort input stops the operation in progress at once. While the abort input is high, read data is disabled. A word whose program was cut short is left holding a corruption value.

Top module: `pe_engine`

## Requirements
- R1: After reset, every array word reads as all ones (the erased state).
- R2: A program request writes old AND new data to the addressed word, so bits can only go from 1 to 0.
- R3: `busy_o` rises in the cycle after a request is accepted. It stays high for PROG_CYC cycles for a program, and for ERASE_CYC plus the length cycles for an erase.
- R4: An erase sets the words from start to start+length-1, modulo the depth, to all ones and leaves every other word unchanged. An erase whose length is 0 is not accepted.
- R5: A read issued while busy returns a status word. Its bit 7 is the complement of bit 7 of the loaded data during a program, and 0 during an erase. All bits other than 7 and 6 are 0.
- R6: Bit 6 of the status word is 1 on the first read of an operation and flips on each later read during that operation.
- R7: A request that arrives while busy is dropped. It does not change the array, and it does not start an operation afterwards.
- R8: Requests that arrive before POR_CYC cycles have passed since reset are dropped.
- R9: With `abort_i` high, `busy_o` is low from the next cycle on and `rd_valid_o` stays low. A program that is aborted leaves its word holding CORRUPT_WORD. An erase aborted before its first write changes no word.
- R10: `arr_we_o` is high in the last busy cycle of a program, carrying the address and the ANDed word. For an erase it is high in each of the last length cycles, with addresses counting up from start and data all ones.
- R11: A read issued in a cycle gives `rd_valid_o` and `rd_data_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_i | input | 1 | Halts the current operation and disables read data |
| req_i | input | 1 | Request strobe |
| req_erase_i | input | 1 | 1 = erase, 0 = program |
| req_addr_i | input | AW | Program address or erase start address |
| req_data_i | input | DW | Program data |
| req_len_i | input | AW+1 | Erase length in words |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | AW | Read address |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | DW | Array word, or status word while busy |
| busy_o | output | 1 | Operation in progress |
| arr_we_o | output | 1 | Array write strobe |
| arr_waddr_o | output | AW | Array write address |
| arr_wdata_o | output | DW | Array write data |

## Verification
The bench targets four corner cases.

- **Repeated programs to one word.** A design that overwrote the word instead of ANDing it would hand back bits set to 1 again.
- **An erase range that wraps past the top address.** A design without the modulo would write past the array or stop at the top, leaving words 0 to 3 programmed.
- **A second request during busy.** A design that queued or accepted it would erase the whole array.
- **Aborts at different points.** An abort during a program must leave the corruption pattern. An abort during the erase wait must leave the range untouched. A design that got the abort wrong would show a clean word in the first case or an erased range in the second.

Status reads are issued on random cycles. A toggle that kept its phase across operations, or moved without a read, would break the alternation the bench expects.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PROG   = 2'd1,
    ST_EWAIT  = 2'd2,
    ST_EWRITE = 2'd3
  } pe_state_t;

  localparam int POLL_BIT   = 7;
  localparam int TOGGLE_BIT = 6;
endpackage

// File: rtl/pe_por_timer.sv
module pe_por_timer #(
  parameter int POR_CYC = 50
) (
  input  logic clk,
  input  logic rst,
  output logic done_o
);
  localparam int CW = $clog2(POR_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (!done_o) begin
      cnt_q  <= cnt_q + 1'b1;
      done_o <= (cnt_q == CW'(POR_CYC - 1));
    end
  end

  // R8
  por_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);
endmodule

// File: rtl/pe_word_ram.sv
module pe_word_ram #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/pe_seq.sv
module pe_seq
  import pe_pkg::*;
#(
  parameter int DW           = 16,
  parameter int AW           = 6,
  parameter int PROG_CYC     = 12,
  parameter int ERASE_CYC    = 20,
  parameter bit CORRUPT_X    = 1'b0,
  parameter logic [DW-1:0] CORRUPT_WORD = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort_i,
  input  logic          por_ok_i,
  input  logic          req_i,
  input  logic          req_erase_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  input  logic [AW:0]   req_len_i,
  input  logic          rd_en_i,
  input  logic [DW-1:0] old_word_i,
  output logic          busy_o,
  output logic [AW-1:0] op_addr_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] stat_o
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  pe_state_t     state_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] op_data_q;
  logic [AW:0]   op_len_q;
  logic [AW:0]   left_q;
  logic          op_erase_q;
  logic          toggle_q;
  logic          accept;
  logic [DW-1:0] corrupt_w;
  logic [DW-1:0] stat_next;

  generate
    if (CORRUPT_X) begin : g_corrupt_x
      assign corrupt_w = {DW{1'bx}};
    end else begin : g_corrupt_pat
      assign corrupt_w = CORRUPT_WORD;
    end
  endgenerate

  assign accept = req_i && !busy_o && por_ok_i && !abort_i &&
                  (!req_erase_i || (req_len_i != '0));

  always_comb begin
    stat_next             = '0;
    stat_next[POLL_BIT]   = op_erase_q ? 1'b0 : ~op_data_q[POLL_BIT];
    stat_next[TOGGLE_BIT] = ~toggle_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      busy_o     <= 1'b0;
      cnt_q      <= '0;
      op_addr_o  <= '0;
      op_data_q  <= '0;
      op_len_q   <= '0;
      op_erase_q <= 1'b0;
      left_q     <= '0;
      we_o       <= 1'b0;
      waddr_o    <= '0;
      wdata_o    <= '0;
    end else if (abort_i) begin
      state_q <= ST_IDLE;
      busy_o  <= 1'b0;
      we_o    <= (state_q == ST_PROG);
      waddr_o <= op_addr_o;
      wdata_o <= corrupt_w;
    end else begin
      case (state_q)
        ST_IDLE: begin
          we_o <= 1'b0;
          if (accept) begin
            busy_o     <= 1'b1;
            op_addr_o  <= req_addr_i;
            op_data_q  <= req_data_i;
            op_len_q   <= req_len_i;
            op_erase_q <= req_erase_i;
            if (req_erase_i) begin
              state_q <= ST_EWAIT;
              cnt_q   <= CW'(ERASE_CYC - 1);
            end else begin
              state_q <= ST_PROG;
              cnt_q   <= CW'(PROG_CYC - 1);
            end
          end
        end
        ST_PROG: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) begin
            we_o    <= 1'b1;
            waddr_o <= op_addr_o;
            wdata_o <= old_word_i & op_data_q;
          end else if (cnt_q == '0) begin
            we_o    <= 1'b0;
            busy_o  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_EWAIT: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == '0) begin
            state_q <= ST_EWRITE;
            we_o    <= 1'b1;
            waddr_o <= op_addr_o;
            wdata_o <= '1;
            left_q  <= op_len_q - 1'b1;
          end
        end
        ST_EWRITE: begin
          if (left_q == '0) begin
            we_o    <= 1'b0;
            busy_o  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            waddr_o <= waddr_o + 1'b1;
            left_q  <= left_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      toggle_q <= 1'b0;
      stat_o   <= '0;
    end else if (accept) begin
      toggle_q <= 1'b0;
    end else if (rd_en_i && busy_o && !abort_i) begin
      toggle_q <= ~toggle_q;
      stat_o   <= stat_next;
    end
  end

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(req_i) && $past(por_ok_i));
  // R10
  last_write_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) && !$past(abort_i) |-> $past(we_o));
  // R7
  op_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o && $past(busy_o) |-> $stable(op_addr_o) && $stable(op_data_q));
  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en_i && busy_o && !abort_i && !accept |=> toggle_q != $past(toggle_q));
  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> !busy_o);
endmodule

// File: rtl/pe_engine.sv
module pe_engine #(
  parameter int DW           = 16,
  parameter int AW           = 6,
  parameter int PROG_CYC     = 12,
  parameter int ERASE_CYC    = 20,
  parameter int POR_CYC      = 50,
  parameter bit CORRUPT_X    = 1'b0,
  parameter logic [DW-1:0] CORRUPT_WORD = 16'hDEAD
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort_i,
  input  logic          req_i,
  input  logic          req_erase_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  input  logic [AW:0]   req_len_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          busy_o,
  output logic          arr_we_o,
  output logic [AW-1:0] arr_waddr_o,
  output logic [DW-1:0] arr_wdata_o
);
  logic          por_ok;
  logic [AW-1:0] op_addr;
  logic [AW-1:0] ram_raddr;
  logic [DW-1:0] ram_q;
  logic [DW-1:0] stat;
  logic          sel_stat_q;

  pe_por_timer #(.POR_CYC(POR_CYC)) i_por (
    .clk(clk), .rst(rst), .done_o(por_ok)
  );

  pe_seq #(
    .DW(DW), .AW(AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
    .CORRUPT_X(CORRUPT_X), .CORRUPT_WORD(CORRUPT_WORD)
  ) i_seq (
    .clk(clk), .rst(rst), .abort_i(abort_i), .por_ok_i(por_ok),
    .req_i(req_i), .req_erase_i(req_erase_i), .req_addr_i(req_addr_i),
    .req_data_i(req_data_i), .req_len_i(req_len_i), .rd_en_i(rd_en_i),
    .old_word_i(ram_q), .busy_o(busy_o), .op_addr_o(op_addr),
    .we_o(arr_we_o), .waddr_o(arr_waddr_o), .wdata_o(arr_wdata_o),
    .stat_o(stat)
  );

  assign ram_raddr = busy_o ? op_addr : rd_addr_i;

  pe_word_ram #(.DW(DW), .AW(AW)) i_ram (
    .clk(clk), .we_i(arr_we_o), .waddr_i(arr_waddr_o), .wdata_i(arr_wdata_o),
    .raddr_i(ram_raddr), .rdata_o(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      sel_stat_q <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i && !abort_i;
      sel_stat_q <= busy_o;
    end
  end

  assign rd_data_o = sel_stat_q ? stat : ram_q;

  // R11
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> $past(rd_en_i) && !$past(abort_i));
endmodule

// File: tb/test_pe_engine.sv
module test_pe_engine;
  localparam int DW = 16, AW = 6, DEPTH = 64;
  localparam int PROG_CYC = 12, ERASE_CYC = 20, POR_CYC = 50;
  localparam logic [15:0] CORRUPT = 16'hDEAD;

  logic clk = 1'b0, rst = 1'b1, abort_i = 1'b0;
  logic req_i = 1'b0, req_erase_i = 1'b0, rd_en_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0, rd_addr_i = '0;
  logic [DW-1:0] req_data_i = '0;
  logic [AW:0]   req_len_i = '0;
  logic rd_valid_o, busy_o, arr_we_o;
  logic [DW-1:0] rd_data_o, arr_wdata_o;
  logic [AW-1:0] arr_waddr_o;

  int total = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] model_mem [DEPTH];

  always #4 clk = ~clk;

  pe_engine #(.DW(DW), .AW(AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
              .POR_CYC(POR_CYC), .CORRUPT_WORD(CORRUPT)) i_pe_engine (
    .clk(clk), .rst(rst), .abort_i(abort_i), .req_i(req_i),
    .req_erase_i(req_erase_i), .req_addr_i(req_addr_i), .req_data_i(req_data_i),
    .req_len_i(req_len_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .busy_o(busy_o),
    .arr_we_o(arr_we_o), .arr_waddr_o(arr_waddr_o), .arr_wdata_o(arr_wdata_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_status(input bit er, input logic [15:0] d,
                                             input int n);
    logic [15:0] s;
    s    = '0;
    s[7] = er ? 1'b0 : ~d[7];
    s[6] = n[0];
    return s;
  endfunction

  task automatic read_check(input logic [AW-1:0] a, input logic [15:0] e,
                            input string tag);
    @(negedge clk); rd_en_i = 1'b1; rd_addr_i = a;
    @(negedge clk); rd_en_i = 1'b0;
    chk(rd_valid_o && rd_data_o == e, tag, {15'd0, rd_valid_o, rd_data_o},
        {15'd0, 1'b1, e});
  endtask

  task automatic fire(input bit er, input logic [AW-1:0] a, input logic [15:0] d,
                      input int len);
    @(negedge clk);
    req_i = 1'b1; req_erase_i = er; req_addr_i = a; req_data_i = d;
    req_len_i = (AW+1)'(len);
    @(negedge clk); req_i = 1'b0;
  endtask

  task automatic run_op(input bit er, input logic [AW-1:0] a, input logic [15:0] d,
                        input int len);
    int cyc, nrd, nwe;
    bit pend;
    logic [15:0] pexp, newv;
    newv = model_mem[a] & d;
    fire(er, a, d, len);
    if (er && len == 0) begin
      chk(busy_o == 1'b0, "R4 zero-length erase accepted", busy_o, 0);
      return;
    end
    chk(busy_o == 1'b1, "R3 busy after accept", busy_o, 1);
    cyc = 0; nrd = 0; nwe = 0; pend = 1'b0; pexp = '0;
    while (1) begin
      if (pend) begin
        chk(rd_valid_o && rd_data_o == pexp, "R5 R6 status word", rd_data_o, pexp);
        pend = 1'b0;
      end
      rd_en_i = 1'b0;
      if (!busy_o || cyc > 2000) break;
      cyc++;
      if (arr_we_o) begin
        if (er)
          chk(arr_waddr_o == AW'(int'(a) + nwe) && arr_wdata_o == '1 &&
              cyc == ERASE_CYC + 1 + nwe, "R10 erase strobe",
              {arr_waddr_o, arr_wdata_o}, {AW'(int'(a) + nwe), 16'hFFFF});
        else
          chk(arr_waddr_o == a && arr_wdata_o == newv && cyc == PROG_CYC,
              "R10 program strobe", {arr_waddr_o, arr_wdata_o}, {a, newv});
        nwe++;
      end
      if ($urandom_range(0, 1) == 1) begin
        rd_en_i = 1'b1; rd_addr_i = AW'($urandom);
        nrd++; pexp = exp_status(er, d, nrd); pend = 1'b1;
      end
      @(negedge clk);
    end
    chk(cyc == (er ? ERASE_CYC + len : PROG_CYC), "R3 busy length", cyc,
        er ? ERASE_CYC + len : PROG_CYC);
    chk(nwe == (er ? len : 1), "R10 strobe count", nwe, er ? len : 1);
    if (er) begin
      for (int k = 0; k < len; k++) model_mem[AW'(int'(a) + k)] = '1;
    end else begin
      model_mem[a] = newv;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    for (int i = 0; i < DEPTH; i++) model_mem[i] = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_o == 0 && rd_valid_o == 0 && arr_we_o == 0, "R3 reset state",
        {busy_o, rd_valid_o, arr_we_o}, 0);

    // R8: request during power-on lockout is dropped
    fire(1'b0, 6'd5, 16'h0000, 0);
    chk(busy_o == 1'b0, "R8 request during lockout", busy_o, 0);
    repeat (POR_CYC + 5) @(negedge clk);
    read_check(6'd5, 16'hFFFF, "R8 word unchanged after lockout");

    // R1: erased array
    for (int i = 0; i < DEPTH; i++) read_check(AW'(i), 16'hFFFF, "R1 erased state");

    // R2: AND semantics, both polarities of bit 7
    run_op(1'b0, 6'd3, 16'h00FF, 0);
    run_op(1'b0, 6'd3, 16'hF0F0, 0);
    read_check(6'd3, 16'h00F0, "R2 program ANDs");
    run_op(1'b0, 6'd10, 16'h1234, 0);
    read_check(6'd10, 16'h1234, "R2 program word");

    // R4: wrapping erase
    run_op(1'b0, 6'd4, 16'h0000, 0);
    run_op(1'b0, 6'd59, 16'h5555, 0);
    run_op(1'b0, 6'd0, 16'h1111, 0);
    run_op(1'b1, 6'd60, 16'h0000, 8);
    read_check(6'd0, 16'hFFFF, "R4 wrapped word erased");
    read_check(6'd3, 16'hFFFF, "R4 range end erased");
    read_check(6'd4, 16'h0000, "R4 word past range kept");
    read_check(6'd59, 16'h5555, "R4 word before range kept");
    run_op(1'b1, 6'd4, 16'h0000, 0);
    read_check(6'd4, 16'h0000, "R4 zero-length erase no effect");

    // R7: request during busy dropped
    fire(1'b0, 6'd20, 16'h0F0F, 0);
    @(negedge clk);
    fire(1'b1, 6'd0, 16'h0000, 64);
    while (busy_o) @(negedge clk);
    @(negedge clk);
    chk(busy_o == 1'b0, "R7 no queued operation", busy_o, 0);
    model_mem[20] = model_mem[20] & 16'h0F0F;
    read_check(6'd4, 16'h0000, "R7 ignored erase left array");
    read_check(6'd20, 16'h0F0F, "R7 first program completed");

    // R9: abort during program
    fire(1'b0, 6'd30, 16'h0000, 0);
    repeat (3) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0, "R9 busy drops on abort", busy_o, 0);
    rd_en_i = 1'b1; rd_addr_i = 6'd30;
    @(negedge clk);
    chk(rd_valid_o == 1'b0, "R9 read disabled during abort", rd_valid_o, 0);
    rd_en_i = 1'b0; abort_i = 1'b0;
    @(negedge clk);
    model_mem[30] = CORRUPT;
    read_check(6'd30, CORRUPT, "R9 aborted program corrupts word");

    // R9: abort during erase wait
    run_op(1'b0, 6'd40, 16'h0000, 0);
    fire(1'b1, 6'd40, 16'h0000, 4);
    repeat (5) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0, "R9 erase aborted", busy_o, 0);
    abort_i = 1'b0;
    @(negedge clk);
    read_check(6'd40, 16'h0000, "R9 aborted erase left word");

    // random mix
    for (int n = 0; n < 24; n++) begin
      bit er;
      er = ($urandom_range(0, 3) == 0);
      run_op(er, AW'($urandom), 16'($urandom), int'($urandom_range(0, 12)));
    end
    for (int i = 0; i < DEPTH; i++)
      read_check(AW'(i), model_mem[i], "R2 R4 final array compare");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule